// File: doc/BRIEF.md
# Accelerator Command Queue

This block buffers register and memory-mapped writes from a host on their way to a 2D drawing engine. Every accepted write is stored as a data value plus a single 32-bit tag word. The top byte of the tag names the write kind: memory or port, and byte, word or dword size. The lower bits hold the address. Entries sit in a ring buffer indexed by free-running read and write counters. A drain side replays them in arrival order to the engine over a valid/ready handshake.

The queue reports itself full a fixed guard distance before its true capacity, and a host write that meets a full queue stalls. A status word is built from live occupancy: busy, empty, full, and a read-data-available flag supplied from outside. Host reads of engine parameters are held until the queue is empty. Each time the drain empties the queue, a sticky empty-interrupt flag is raised. With queueing switched off, writes pass straight through to the engine and reads are not held.

Top module: `cmd_queue`

## Requirements
- R1: After reset the queue is empty, `ds_valid` and `irq_empty` are 0, `hw_ready` is 1, and with `queue_en`=1 and the side inputs low `status_word` is 16'h0400.
- R2: `hw_kind` codes are 0/1/2 for memory byte/word/dword and 4/5/6 for port byte/word/dword. Queued entries come out on `ds_kind`/`ds_addr`/`ds_data` strictly in arrival order, one per cycle in which `ds_valid` and `ds_ready` are both high.
- R3: With `queue_en`=1 and occupancy at or above DEPTH-GUARD (12 by default), `hw_ready` is 0 and the write stalls without loss. `status_word[7:0]` is 8'hFF while full and 8'h00 otherwise.
- R4: With `queue_en`=1, `status_word[9]` (busy) is 1 when the queue holds entries or `force_busy` is 1, and `status_word[10]` (empty) is 1 otherwise. `status_word[8]` follows `data_avail` in every mode.
- R5: With EXT_STATUS=1 (the default), `status_word[15:11]` is all ones while the queue is full and zero otherwise.
- R6: With `queue_en`=1, `rd_grant` is 1 only when `rd_req` is 1 and the queue is empty. With `queue_en`=0, `rd_grant` follows `rd_req` at once.
- R7: `irq_empty` is set in the cycle after a pop that leaves the queue empty, and it holds until `irq_ack`. A set and an ack in the same cycle leave it set. A pop of the last entry that coincides with an accepted write does not set it.
- R8: Memory-kind addresses keep their low 17 bits when `reloc_mode` is 1 and their low 16 bits when it is 0, sampled with the write. Port-kind addresses always keep their low 16 bits. All higher bits read as zero on `ds_addr`.
- R9: With `queue_en`=0 and the queue empty, `ds_valid`/`ds_kind`/`ds_addr`/`ds_data` follow the host write in the same cycle (address masked per R8), `hw_ready` equals `ds_ready`, and nothing is stored.
- R10: While the queue is not empty and `ds_ready` is 0, `ds_valid` stays 1 and `ds_addr`/`ds_data` stay unchanged.
- R11: With `queue_en`=0, `status_word[7:0]` and `status_word[15:9]` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| queue_en | input | 1 | 1: writes are queued; 0: writes bypass the buffer |
| reloc_mode | input | 1 | Selects the 17-bit memory address window |
| force_busy | input | 1 | Forces the busy status bit |
| data_avail | input | 1 | Read-data-available flag copied into status |
| hw_valid | input | 1 | Host write request |
| hw_kind | input | 3 | Write kind code (R2) |
| hw_addr | input | ADDR_W | Host write address |
| hw_data | input | DATA_W | Host write data |
| hw_ready | output | 1 | Write accepted this cycle when high with hw_valid |
| rd_req | input | 1 | Host parameter read request |
| rd_grant | output | 1 | Read may complete |
| ds_valid | output | 1 | Entry offered to the engine |
| ds_kind | output | 3 | Kind of the offered entry |
| ds_addr | output | ADDR_W | Masked address of the offered entry |
| ds_data | output | DATA_W | Data of the offered entry |
| ds_ready | input | 1 | Engine takes the offered entry |
| status_word | output | 16 | Live status word |
| irq_ack | input | 1 | Clears the empty interrupt flag |
| irq_empty | output | 1 | Sticky queue-drained interrupt flag |

## Verification
The delicate overlap is a host write accepted in the same cycle as the pop of the last queued entry. At that point occupancy goes 1 to 1 rather than 1 to 0, so the drained interrupt must stay clear. The bench provokes this by raising `hw_valid` and `ds_ready` together with a single entry queued. It then judges `irq_empty` and the new head one cycle later. A second overlap is an interrupt acknowledge in the very cycle that a drain sets the flag, where the set must win. The stall path is also covered: a write held against a full queue must enter on the cycle after one slot frees and then appear last in drain order.

// File: rtl/cq_pkg.sv
package cq_pkg;
    // tag byte: bit 7 marks a live slot, bits 2:0 carry the write kind
    localparam logic [7:0] TYPE_EMPTY = 8'h00;
    localparam int KIND_W = 3;
    localparam int KIND_PORT_BIT = 2;
    localparam int NARROW_ADDR_W = 16;
    localparam int WIDE_ADDR_W = 17;

    function automatic logic [7:0] make_type(input logic [KIND_W-1:0] kind);
        return {1'b1, 4'b0000, kind};
    endfunction
endpackage

// File: rtl/cq_ring.sv
module cq_ring #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int IDX_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [7:0]        push_type,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [7:0]        head_type,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic [IDX_W-1:0]  occ
);
    import cq_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] wr;
        logic [IDX_W-1:0] rd;
    } ptr_t;

    ptr_t st_d, st_q;

    logic [7:0]        type_q [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    logic [SLOT_W-1:0] wr_slot, rd_slot;

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = st_q.wr + 1'b1;
        if (pop)  st_d.rd = st_q.rd + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_slot = st_q.wr[SLOT_W-1:0];
    assign rd_slot = st_q.rd[SLOT_W-1:0];
    assign occ     = st_q.wr - st_q.rd;

    // tag storage: a consumed slot is marked empty
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) type_q[i] <= TYPE_EMPTY;
        end else begin
            if (pop)  type_q[rd_slot] <= TYPE_EMPTY;
            if (push) type_q[wr_slot] <= push_type;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_slot] <= push_addr;
            data_q[wr_slot] <= push_data;
        end
    end

    assign head_type = type_q[rd_slot];
    assign head_addr = addr_q[rd_slot];
    assign head_data = data_q[rd_slot];
endmodule

// File: rtl/cq_status.sv
module cq_status #(
    parameter int DEPTH      = 16,
    parameter int GUARD      = 4,
    parameter bit EXT_STATUS = 1'b1,
    localparam int IDX_W     = $clog2(DEPTH) + 1,
    localparam int FULL_AT   = DEPTH - GUARD
) (
    input  logic             queue_en,
    input  logic [IDX_W-1:0] occ,
    input  logic             force_busy,
    input  logic             data_avail,
    output logic             full,
    output logic [15:0]      status_word
);
    logic [4:0] ext_bits;
    logic [7:0] lo_byte, hi_byte;

    assign full = (occ >= IDX_W'(FULL_AT));

    generate
        if (EXT_STATUS) begin : g_ext
            assign ext_bits = {5{full}};
        end else begin : g_noext
            assign ext_bits = 5'b0;
        end
    endgenerate

    always_comb begin
        lo_byte    = 8'h00;
        hi_byte    = 8'h00;
        hi_byte[0] = data_avail;
        if (queue_en) begin
            if (full) lo_byte = 8'hFF;
            if ((occ != '0) || force_busy) hi_byte[1] = 1'b1;
            else                           hi_byte[2] = 1'b1;
            hi_byte[7:3] = ext_bits;
        end
    end

    assign status_word = {hi_byte, lo_byte};
endmodule

// File: rtl/cmd_queue.sv
module cmd_queue #(
    parameter int DEPTH      = 16,
    parameter int GUARD      = 4,
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 32,
    parameter bit EXT_STATUS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              queue_en,
    input  logic              reloc_mode,
    input  logic              force_busy,
    input  logic              data_avail,
    input  logic              hw_valid,
    input  logic [2:0]        hw_kind,
    input  logic [ADDR_W-1:0] hw_addr,
    input  logic [DATA_W-1:0] hw_data,
    output logic              hw_ready,
    input  logic              rd_req,
    output logic              rd_grant,
    output logic              ds_valid,
    output logic [2:0]        ds_kind,
    output logic [ADDR_W-1:0] ds_addr,
    output logic [DATA_W-1:0] ds_data,
    input  logic              ds_ready,
    output logic [15:0]       status_word,
    input  logic              irq_ack,
    output logic              irq_empty
);
    import cq_pkg::*;

    localparam int IDX_W = $clog2(DEPTH) + 1;
    localparam logic [ADDR_W-1:0] MASK_NARROW = ADDR_W'((1 << NARROW_ADDR_W) - 1);
    localparam logic [ADDR_W-1:0] MASK_WIDE   = ADDR_W'((1 << WIDE_ADDR_W) - 1);

    typedef struct packed {
        logic irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              full, empty, push, pop, drained;
    logic [IDX_W-1:0]  occ;
    logic [7:0]        head_type;
    logic [ADDR_W-1:0] head_addr, masked_addr;
    logic [DATA_W-1:0] head_data;

    // address window chosen at the time of the write
    always_comb begin
        if (hw_kind[KIND_PORT_BIT])  masked_addr = hw_addr & MASK_NARROW;
        else if (reloc_mode)         masked_addr = hw_addr & MASK_WIDE;
        else                         masked_addr = hw_addr & MASK_NARROW;
    end

    cq_ring #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_type(make_type(hw_kind)),
        .push_addr(masked_addr),
        .push_data(hw_data),
        .pop      (pop),
        .head_type(head_type),
        .head_addr(head_addr),
        .head_data(head_data),
        .occ      (occ)
    );

    cq_status #(
        .DEPTH     (DEPTH),
        .GUARD     (GUARD),
        .EXT_STATUS(EXT_STATUS)
    ) u_status (
        .queue_en   (queue_en),
        .occ        (occ),
        .force_busy (force_busy),
        .data_avail (data_avail),
        .full       (full),
        .status_word(status_word)
    );

    assign empty    = (occ == '0);
    assign push     = queue_en && hw_valid && !full;
    assign hw_ready = queue_en ? !full : (empty && ds_ready);
    assign ds_valid = empty ? (!queue_en && hw_valid) : (head_type != TYPE_EMPTY);
    assign ds_kind  = empty ? hw_kind     : head_type[2:0];
    assign ds_addr  = empty ? masked_addr : head_addr;
    assign ds_data  = empty ? hw_data     : head_data;
    assign pop      = !empty && ds_ready;
    assign rd_grant = rd_req && (empty || !queue_en);
    assign drained  = pop && (occ == IDX_W'(1)) && !push;

    always_comb begin
        ctl_d = ctl_q;
        if (irq_ack) ctl_d.irq = 1'b0;
        if (drained) ctl_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_empty = ctl_q.irq;
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
    parameter int DEPTH      = 16,
    parameter int GUARD      = 4,
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 32,
    parameter bit EXT_STATUS = 1'b1,
    localparam int IDX_W     = $clog2(DEPTH) + 1,
    localparam int FULL_AT   = DEPTH - GUARD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              queue_en,
    input logic              hw_valid,
    input logic              hw_ready,
    input logic              rd_grant,
    input logic              ds_valid,
    input logic [ADDR_W-1:0] ds_addr,
    input logic [DATA_W-1:0] ds_data,
    input logic              ds_ready,
    input logic [15:0]       status_word,
    input logic              irq_empty,
    input logic [IDX_W-1:0]  occ
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= IDX_W'(FULL_AT)); // R3

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_en && status_word[7:0] == 8'hFF) |-> !hw_ready); // R3

    AST_BUSY_XOR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        queue_en |-> ($countones(status_word[10:9]) == 1)); // R4

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant && queue_en) |-> !ds_valid); // R6

    AST_IRQ_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == IDX_W'(1) && ds_ready && !(queue_en && hw_valid && hw_ready)) |=> irq_empty); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (occ != '0 && !ds_ready) |=> (ds_valid && $stable(ds_addr) && $stable(ds_data))); // R10

    generate
        if (EXT_STATUS) begin : g_ext_chk
            AST_EXT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
                (queue_en && status_word[7:0] == 8'hFF) |-> (status_word[15:11] == 5'h1F)); // R5
        end
    endgenerate
endmodule

bind cmd_queue cq_checker #(
    .DEPTH     (DEPTH),
    .GUARD     (GUARD),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .EXT_STATUS(EXT_STATUS)
) u_cq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .queue_en   (queue_en),
    .hw_valid   (hw_valid),
    .hw_ready   (hw_ready),
    .rd_grant   (rd_grant),
    .ds_valid   (ds_valid),
    .ds_addr    (ds_addr),
    .ds_data    (ds_data),
    .ds_ready   (ds_ready),
    .status_word(status_word),
    .irq_empty  (irq_empty),
    .occ        (occ)
);

// File: tb/test_cmd_queue.sv
module test_cmd_queue;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [2:0]  kind;
        logic        reloc;
        logic [23:0] addr;
        logic [31:0] data;
        logic [23:0] exp_addr;
    } vec_t;

    // R2 / R8 vectors: kind, relocation mode, raw address, data, expected masked address
    localparam vec_t VECS [8] = '{
        '{3'd0, 1'b0, 24'h01A2B4, 32'h0000_00A1, 24'h00A2B4},
        '{3'd1, 1'b1, 24'h038118, 32'h0000_B2C3, 24'h018118},
        '{3'd2, 1'b0, 24'hFFFFFF, 32'hDEAD_BEEF, 24'h00FFFF},
        '{3'd4, 1'b1, 24'h129AE8, 32'h0000_005A, 24'h009AE8},
        '{3'd5, 1'b0, 24'h00A2E8, 32'h0000_1234, 24'h00A2E8},
        '{3'd6, 1'b1, 24'h7EBEE8, 32'h8765_4321, 24'h00BEE8},
        '{3'd2, 1'b1, 24'h050001, 32'h0BAD_F00D, 24'h010001},
        '{3'd0, 1'b0, 24'h010001, 32'h0000_0077, 24'h000001}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        queue_en, reloc_mode, force_busy, data_avail;
    logic        hw_valid, hw_ready;
    logic [2:0]  hw_kind;
    logic [23:0] hw_addr;
    logic [31:0] hw_data;
    logic        rd_req, rd_grant;
    logic        ds_valid, ds_ready;
    logic [2:0]  ds_kind;
    logic [23:0] ds_addr;
    logic [31:0] ds_data;
    logic [15:0] status_word;
    logic        irq_ack, irq_empty;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_queue i_cmd_queue (
        .clk(clk), .rst_n(rst_n), .queue_en(queue_en), .reloc_mode(reloc_mode),
        .force_busy(force_busy), .data_avail(data_avail),
        .hw_valid(hw_valid), .hw_kind(hw_kind), .hw_addr(hw_addr), .hw_data(hw_data),
        .hw_ready(hw_ready), .rd_req(rd_req), .rd_grant(rd_grant),
        .ds_valid(ds_valid), .ds_kind(ds_kind), .ds_addr(ds_addr), .ds_data(ds_data),
        .ds_ready(ds_ready), .status_word(status_word), .irq_ack(irq_ack), .irq_empty(irq_empty)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // starts and ends just after a falling edge
    task automatic put(input logic [2:0] k, input logic rl, input logic [23:0] a, input logic [31:0] d);
        hw_valid = 1'b1; hw_kind = k; hw_addr = a; hw_data = d; reloc_mode = rl;
        #1;
        while (!hw_ready) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        hw_valid = 1'b0;
        #1;
    endtask

    task automatic take(input string req, input logic [2:0] k, input logic [23:0] a, input logic [31:0] d);
        chk(req, "ds_valid", ds_valid, 1'b1);
        chk(req, "ds_kind", ds_kind, k);
        chk(req, "ds_addr", ds_addr, a);
        chk(req, "ds_data", ds_data, d);
        ds_ready = 1'b1;
        @(negedge clk);
        ds_ready = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; queue_en = 1'b1; reloc_mode = 1'b0; force_busy = 1'b0; data_avail = 1'b0;
        hw_valid = 1'b0; hw_kind = 3'd0; hw_addr = '0; hw_data = '0;
        rd_req = 1'b0; ds_ready = 1'b0; irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk("R1", "status", status_word, 16'h0400);
        chk("R1", "ds_valid", ds_valid, 1'b0);
        chk("R1", "irq", irq_empty, 1'b0);
        chk("R1", "hw_ready", hw_ready, 1'b1);

        // R2 / R8 table walk
        for (int i = 0; i < 8; i++) put(VECS[i].kind, VECS[i].reloc, VECS[i].addr, VECS[i].data);
        chk("R4", "busy status", status_word, 16'h0200);
        rd_req = 1'b1; #1;
        chk("R6", "grant held", rd_grant, 1'b0);
        for (int i = 0; i < 8; i++) take("R2", VECS[i].kind, VECS[i].exp_addr, VECS[i].data);
        chk("R7", "irq after drain", irq_empty, 1'b1);
        chk("R6", "grant after drain", rd_grant, 1'b1);
        chk("R4", "empty status", status_word, 16'h0400);
        rd_req = 1'b0;
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; #1;
        chk("R7", "irq ack", irq_empty, 1'b0);

        // R3 / R5 fill to threshold and stall
        for (int i = 0; i < 12; i++) put(3'd2, 1'b0, 24'(i), 32'(i));
        chk("R3", "hw_ready full", hw_ready, 1'b0);
        chk("R5", "full status", status_word, 16'hFAFF);
        hw_valid = 1'b1; hw_kind = 3'd4; hw_addr = 24'h000100; hw_data = 32'd100;
        @(negedge clk); @(negedge clk); #1;
        chk("R3", "still stalled", hw_ready, 1'b0);
        take("R3", 3'd2, 24'h0, 32'd0);
        chk("R3", "low byte after pop", status_word[7:0], 8'h00);
        @(negedge clk); hw_valid = 1'b0; #1;
        chk("R3", "full again", status_word[7:0], 8'hFF);
        for (int i = 1; i < 12; i++) take("R2", 3'd2, 24'(i), 32'(i));
        take("R3", 3'd4, 24'h000100, 32'd100);
        chk("R7", "irq after full drain", irq_empty, 1'b1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; #1;

        // R4 side flags with an empty queue
        force_busy = 1'b1; #1;
        chk("R4", "force busy", status_word, 16'h0200);
        data_avail = 1'b1; #1;
        chk("R4", "busy+avail", status_word, 16'h0300);
        force_busy = 1'b0; #1;
        chk("R4", "empty+avail", status_word, 16'h0500);
        data_avail = 1'b0; #1;

        // R7 write coinciding with the last pop
        put(3'd0, 1'b0, 24'h000001, 32'h11);
        hw_valid = 1'b1; hw_kind = 3'd0; hw_addr = 24'h000002; hw_data = 32'h22; ds_ready = 1'b1;
        #1;
        chk("R7", "head before overlap", ds_data, 32'h11);
        @(negedge clk);
        hw_valid = 1'b0; ds_ready = 1'b0; #1;
        chk("R7", "no irq on overlap", irq_empty, 1'b0);
        take("R7", 3'd0, 24'h000002, 32'h22);
        chk("R7", "irq after real drain", irq_empty, 1'b1);

        // R7 set and ack in the same cycle: set wins
        put(3'd1, 1'b0, 24'h000003, 32'h33);
        irq_ack = 1'b1;
        take("R7", 3'd1, 24'h000003, 32'h33);
        irq_ack = 1'b0;
        chk("R7", "set beats ack", irq_empty, 1'b1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; #1;

        // R10 hold while engine stalls
        put(3'd6, 1'b0, 24'h00BEE8, 32'hCAFE_0001);
        repeat (3) @(negedge clk);
        #1;
        chk("R10", "held data", ds_data, 32'hCAFE_0001);
        take("R10", 3'd6, 24'h00BEE8, 32'hCAFE_0001);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; #1;

        // R9 / R11 bypass
        queue_en = 1'b0; #1;
        chk("R11", "status off", status_word, 16'h0000);
        data_avail = 1'b1; #1;
        chk("R11", "status off avail", status_word, 16'h0100);
        rd_req = 1'b1; #1;
        chk("R6", "grant bypass", rd_grant, 1'b1);
        rd_req = 1'b0;
        hw_valid = 1'b1; hw_kind = 3'd1; reloc_mode = 1'b1; hw_addr = 24'hF34567; hw_data = 32'hABCD;
        #1;
        chk("R9", "bypass valid", ds_valid, 1'b1);
        chk("R9", "bypass addr", ds_addr, 24'h014567);
        chk("R9", "bypass data", ds_data, 32'hABCD);
        chk("R9", "bypass stall", hw_ready, 1'b0);
        ds_ready = 1'b1; #1;
        chk("R9", "bypass ready", hw_ready, 1'b1);
        @(negedge clk);
        hw_valid = 1'b0; ds_ready = 1'b0; #1;
        chk("R9", "nothing stored", ds_valid, 1'b0);
        chk("R9", "no irq", irq_empty, 1'b0);
        data_avail = 1'b0;

        finish_run();
    end
endmodule